// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block sends and receives asynchronous serial frames in both directions at once. It sits behind a small register port with three locations: a data register, a status register and a control register. A write to the data register starts a frame on `txd`. A frame that arrives on `rxd` is placed in the same data location for reading. The control register sets the word length (eight or nine data bits) and turns on optional parity. When parity is on, the parity bit takes the place of the top data bit, so the frame does not grow.

A parity mismatch on a received word sets an error flag. That flag drives a level interrupt that a downstream edge detector can pick up. The flag clears only when software reads the status register and then accesses the data register. Software can mute the receiver. A muted receiver wakes either when the line stays idle for a whole frame time or when a word arrives with its top data bit set.

A disable bit stops the clock enable, `txd` and frame acceptance once the frame in progress has finished. The block does not divide the baud rate itself. `tick16` is supplied from outside at `OVS` pulses per bit.

Top module: `asc_xcvr`

## Requirements
- R1: After reset, control bits 6..0 read 0 and control bit 7 holds no defined value. Status reads 0, `txd` is 1 and `par_irq` is 0.
- R2: With control bit 0 (`wide`) at 0, a transmitted frame has these parts, each lasting `OVS` ticks: a start bit at 0, then eight data bits sent LSB first, then a stop bit at 1.
- R3: With `wide` at 1, a frame carries nine data bits. On transmit, the ninth bit comes from control bit 6. On receive, the ninth bit is stored into control bit 7.
- R4: With control bit 1 (parity enable) set, the parity bit replaces data bit 7 when `wide` is 0 and data bit 8 when `wide` is 1. It is computed over the data bits below that position.
- R5: Control bit 2 selects the parity sense. A 0 makes the count of ones in the data bits plus the parity bit even. A 1 makes that count odd.
- R6: A received word is written to the data register (address 0) and sets status bit 2. A read of the data register clears status bit 2.
- R7: A received word that fails its parity check sets status bit 0. `par_irq` is 1 exactly while status bit 0 and control bit 3 are both 1.
- R8: Status bit 0 is cleared only by an access to the data register that follows a read of the status register (address 1). A data access that no status read preceded leaves it set.
- R9: A change to parity enable or parity select made during a frame, in either direction, takes effect from the next frame. The frame in progress keeps the old setting.
- R10: A write to control bit 0 is dropped while either direction is active. Writes made while both directions are idle take effect.
- R11: When control bit 5 is set, the frame in progress completes. After that, data writes start no frame, `txd` stays 1, status bit 1 (transmit busy) stays 0 and no received frame is accepted.
- R12: Writing the status register with bit 3 set mutes the receiver, and status bit 3 reads 1 while it is muted. Frames that arrive while muted are discarded. With control bit 4 at 1 (address mark), a word whose top data bit is 1 clears the mute and is delivered.
- R13: With control bit 4 at 0 (idle line), the mute clears once the line has stayed high for a full frame time while the receiver is idle.
- R14: The receiver takes each bit as the majority of the three samples at the centre of the bit. A start bit that is not low at mid-bit is rejected, and no frame results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, `OVS` pulses per bit time |
| reg_sel | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, idle high |
| par_irq | output | 1 | Parity error interrupt level |

## Verification
Transmit frames are tried with both word lengths, with parity off, even and odd, and with the ninth bit taken from the control register. Each setting chooses a different bit in the top data position, so a wrong parity placement or sense shows up on the line. Received frames carry correct and deliberately wrong parity, to show that only a real mismatch sets the flag. A short low pulse is driven on the line to separate majority voting from single-sample start detection. Parity, word-length and disable settings are changed while a frame is on the line, which shows whether a setting is taken at frame start or applied at once. Muted reception is tried with words whose top bit is clear and set, and with a long idle gap, to separate the two wake-up methods.

// File: rtl/asc_pkg.sv
package asc_pkg;

    localparam int DATA_W      = 8;
    localparam int WORD_W      = DATA_W + 1;
    localparam int FRAME_MAX   = WORD_W + 2;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int ST_PERR  = 0;
    localparam int ST_TXB   = 1;
    localparam int ST_FULL  = 2;
    localparam int ST_MUTE  = 3;

    // control register, MSB first in this packed order
    typedef struct packed {
        logic rx9;
        logic tx9;
        logic off;
        logic wake;
        logic pie;
        logic podd;
        logic pen;
        logic wide;
    } ctl_t;

    // the frame settings one direction freezes at frame start
    typedef struct packed {
        logic wide;
        logic pen;
        logic podd;
    } frame_cfg_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    function automatic logic [WORD_W-1:0] build_word(frame_cfg_t c, logic [DATA_W-1:0] d, logic b9);
        logic [WORD_W-1:0] w;
        w = {b9, d};
        if (!c.wide) w[WORD_W-1] = 1'b0;
        if (c.pen) begin
            if (c.wide) w[WORD_W-1] = (^d) ^ c.podd;
            else        w[DATA_W-1] = (^d[DATA_W-2:0]) ^ c.podd;
        end
        return w;
    endfunction

    function automatic logic parity_bad(frame_cfg_t c, logic [WORD_W-1:0] w);
        logic bad;
        bad = 1'b0;
        if (c.pen) begin
            if (c.wide) bad = (^w) != c.podd;
            else        bad = (^w[DATA_W-1:0]) != c.podd;
        end
        return bad;
    endfunction

    function automatic logic top_bit(frame_cfg_t c, logic [WORD_W-1:0] w);
        return c.wide ? w[WORD_W-1] : w[DATA_W-1];
    endfunction

endpackage

// File: rtl/asc_tx.sv
module asc_tx
    import asc_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] data,
    input  logic              b9,
    output logic              busy,
    output logic              txd
);
    localparam int CW = $clog2(OVS);
    localparam int LW = $clog2(FRAME_MAX + 1);

    logic [FRAME_MAX-1:0] sh_q;
    logic [LW-1:0]        left_q;
    logic [CW-1:0]        cnt_q;
    logic                 busy_q;
    logic [WORD_W-1:0]    word_c;

    assign word_c = build_word(cfg, data, b9);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            left_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                sh_q   <= cfg.wide ? {1'b1, word_c, 1'b0}
                                   : {2'b11, word_c[DATA_W-1:0], 1'b0};
                left_q <= cfg.wide ? LW'(FRAME_MAX) : LW'(FRAME_MAX - 1);
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end
        end else if (tick) begin
            if (cnt_q == CW'(OVS - 1)) begin
                cnt_q  <= '0;
                sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
                left_q <= left_q - LW'(1);
                if (left_q == LW'(1)) busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy = busy_q;
    assign txd  = busy_q ? sh_q[0] : 1'b1;

    // R2: every frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !txd);

    // R2: the line only moves on an oversampling tick
    assert_shift_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick) |=> $stable(sh_q));

endmodule

// File: rtl/asc_rx.sv
module asc_rx
    import asc_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_in,
    input  logic              en,
    input  frame_cfg_t        cfg,
    input  logic              idle_clr,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output frame_cfg_t        cfg_used,
    output logic              idle_frame
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int IW  = $clog2(FRAME_MAX * OVS + 1);

    rx_state_e         st_q;
    logic [CW-1:0]     cnt_q;
    logic [1:0]        smp_q;
    logic [3:0]        nb_q;
    logic [WORD_W-1:0] sh_q;
    frame_cfg_t        cq;
    logic              done_q;
    logic              vote;
    logic [3:0]        last_bit;
    logic [IW-1:0]     idle_q;
    logic [IW-1:0]     idle_lim;

    assign vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_in) | (smp_q[0] & rx_in);
    assign last_bit = cq.wide ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            smp_q  <= '0;
            nb_q   <= '0;
            sh_q   <= '0;
            cq     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                if (st_q == RX_IDLE) begin
                    if (en && !rx_in) begin
                        st_q  <= RX_START;
                        cnt_q <= CW'(1);
                        nb_q  <= '0;
                        cq    <= cfg;
                    end
                end else begin
                    cnt_q <= (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + CW'(1);
                    if (cnt_q >= CW'(MID - 1) && cnt_q <= CW'(MID))
                        smp_q <= {smp_q[0], rx_in};
                    if (cnt_q == CW'(MID + 1)) begin
                        case (st_q)
                            RX_START: if (vote) st_q <= RX_IDLE;
                            RX_DATA:  sh_q <= {vote, sh_q[WORD_W-1:1]};
                            RX_STOP: begin
                                done_q <= 1'b1;
                                st_q   <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt_q == CW'(OVS - 1)) begin
                        if (st_q == RX_START) begin
                            st_q <= RX_DATA;
                        end else if (st_q == RX_DATA) begin
                            nb_q <= nb_q + 4'd1;
                            if (nb_q == last_bit) st_q <= RX_STOP;
                        end
                    end
                end
            end
        end
    end

    // idle-line timer: counts ticks of high line while no frame is running
    assign idle_lim = cfg.wide ? IW'(FRAME_MAX * OVS) : IW'((FRAME_MAX - 1) * OVS);

    always_ff @(posedge clk) begin
        if (rst || idle_clr || st_q != RX_IDLE || !rx_in) begin
            idle_q <= '0;
        end else if (tick && idle_q < idle_lim) begin
            idle_q <= idle_q + IW'(1);
        end
    end

    assign idle_frame = (idle_q >= idle_lim);
    assign busy       = (st_q != RX_IDLE);
    assign done       = done_q;
    assign word       = cq.wide ? sh_q : {1'b0, sh_q[WORD_W-1:1]};
    assign cfg_used   = cq;

    // R6: a word is only handed over at the end of a stop bit
    assert_done_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(st_q) == RX_STOP);

    // R14: a frame only begins on a low line
    assert_start_on_low_R14: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(rx_in));

endmodule

// File: rtl/asc_xcvr.sv
module asc_xcvr
    import asc_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       par_irq
);
    ctl_t              ctl_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              full_q, perr_q, armed_q, mute_q;
    logic              tx_busy, rx_busy, rx_done, idle_frame;
    logic [WORD_W-1:0] rx_word;
    frame_cfg_t        cfg_now, rx_cfg;
    logic              rxd_s, tick_g;
    logic              ctl_wr, dat_wr, dat_rd, dat_acc, stat_rd, mute_set;
    logic              deliver, tx_start;

    // input synchroniser
    logic [SYNC_STAGES-1:0] sync_q;
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) sync_q <= rst ? 1'b1 : rxd;
        end else begin : g_syncn
            always_ff @(posedge clk)
                sync_q <= rst ? '1 : {sync_q[SYNC_STAGES-2:0], rxd};
        end
    endgenerate
    assign rxd_s = sync_q[SYNC_STAGES-1];

    assign ctl_wr   = reg_wr && reg_sel == SEL_CTRL;
    assign dat_wr   = reg_wr && reg_sel == SEL_DATA;
    assign dat_rd   = reg_rd && reg_sel == SEL_DATA;
    assign dat_acc  = dat_wr || dat_rd;
    assign stat_rd  = reg_rd && reg_sel == SEL_STAT;
    assign mute_set = reg_wr && reg_sel == SEL_STAT && reg_wdata[ST_MUTE];

    assign cfg_now  = '{wide: ctl_q.wide, pen: ctl_q.pen, podd: ctl_q.podd};
    assign tick_g   = tick16 && (!ctl_q.off || tx_busy || rx_busy);
    assign tx_start = dat_wr && !ctl_q.off;
    assign deliver  = !mute_q || (ctl_q.wake && top_bit(rx_cfg, rx_word));

    asc_tx #(.OVS(OVS)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_g),
        .start (tx_start),
        .cfg   (cfg_now),
        .data  (reg_wdata),
        .b9    (ctl_q.tx9),
        .busy  (tx_busy),
        .txd   (txd)
    );

    asc_rx #(.OVS(OVS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_g),
        .rx_in      (rxd_s),
        .en         (!ctl_q.off),
        .cfg        (cfg_now),
        .idle_clr   (mute_set),
        .busy       (rx_busy),
        .done       (rx_done),
        .word       (rx_word),
        .cfg_used   (rx_cfg),
        .idle_frame (idle_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q.tx9  <= reg_wdata[6];
                ctl_q.off  <= reg_wdata[5];
                ctl_q.wake <= reg_wdata[4];
                ctl_q.pie  <= reg_wdata[3];
                ctl_q.podd <= reg_wdata[2];
                ctl_q.pen  <= reg_wdata[1];
                if (!tx_busy && !rx_busy) ctl_q.wide <= reg_wdata[0];
            end
            if (rx_done && deliver && rx_cfg.wide) ctl_q.rx9 <= rx_word[WORD_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_q <= '0;
            full_q    <= 1'b0;
            perr_q    <= 1'b0;
            armed_q   <= 1'b0;
            mute_q    <= 1'b0;
        end else begin
            if (stat_rd) armed_q <= 1'b1;
            if (dat_acc) begin
                armed_q <= 1'b0;
                if (armed_q) perr_q <= 1'b0;
            end
            if (dat_rd) full_q <= 1'b0;
            if (rx_done && mute_q && ctl_q.wake && top_bit(rx_cfg, rx_word)) mute_q <= 1'b0;
            if (idle_frame && mute_q && !ctl_q.wake) mute_q <= 1'b0;
            if (mute_set) mute_q <= 1'b1;
            if (rx_done && deliver) begin
                rx_data_q <= rx_word[DATA_W-1:0];
                full_q    <= 1'b1;
                if (parity_bad(rx_cfg, rx_word)) perr_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_DATA: reg_rdata = rx_data_q;
            SEL_STAT: reg_rdata = {4'b0, mute_q, full_q, tx_busy, perr_q};
            SEL_CTRL: reg_rdata = ctl_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign par_irq = perr_q && ctl_q.pie;

    // R10: word length frozen while a frame is moving
    assert_wide_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_busy || rx_busy) |=> $stable(ctl_q.wide));

    // R7: the error flag rises only on a completed frame
    assert_perr_from_frame_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_q) |-> $past(rx_done));

    // R8: the error flag falls only through the status-then-data sequence
    assert_perr_clear_seq_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(perr_q) |-> $past(armed_q && dat_acc));

    // R11: no transmission starts while disabled
    assert_no_tx_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !$past(ctl_q.off));

    // R11: line held high when disabled and idle
    assert_txd_high_off_R11: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.off && !tx_busy) |-> txd);

endmodule

// File: tb/asc_xcvr_tb.sv
module asc_xcvr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OVS        = 16;
    localparam int BIT        = OVS * TICK_DIV;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    localparam logic [7:0] C_WIDE = 8'h01;
    localparam logic [7:0] C_PEN  = 8'h02;
    localparam logic [7:0] C_PODD = 8'h04;
    localparam logic [7:0] C_PIE  = 8'h08;
    localparam logic [7:0] C_WAKE = 8'h10;
    localparam logic [7:0] C_OFF  = 8'h20;
    localparam logic [7:0] C_TX9  = 8'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       par_irq;

    int n_chk  = 0;
    int n_fail = 0;

    asc_xcvr #(.OVS(OVS), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick16    (tick16),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rxd       (rxd),
        .txd       (txd),
        .par_irq   (par_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div    = (div == TICK_DIV - 1) ? 0 : div + 1;
            tick16 = (div == 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_sel = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_sel = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_rx(input int nd, input logic [8:0] w);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rxd = w[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // waits for a start bit, then samples each bit at its centre
    task automatic capture_tx(input int nd, output logic [8:0] w, output logic frame_ok);
        int guard = 0;
        while (txd !== 1'b0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT / 2) @(negedge clk);
        frame_ok = (txd == 1'b0);
        w = '0;
        for (int i = 0; i < nd; i++) begin
            repeat (BIT) @(negedge clk);
            w[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        frame_ok = frame_ok && (txd == 1'b1);
        repeat (BIT / 2 + 4) @(negedge clk);
    endtask

    task automatic tx_case(input string req, input logic [7:0] ctl, input logic [7:0] d,
                           input int nd, input logic [8:0] exp);
        logic [8:0] w;
        logic       ok;
        reg_write(A_CTRL, ctl);
        reg_write(A_DATA, d);
        capture_tx(nd, w, ok);
        chk(req, int'(w), int'(exp));
        chk({req, " framing"}, int'(ok), 1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 irq", int'(par_irq), 0);
        reg_read(A_CTRL, v);
        chk("R1 ctrl", int'(v & 8'h7F), 0);
        reg_read(A_STAT, v);
        chk("R1 status", int'(v), 0);
    endtask

    task automatic t_tx_frames();
        tx_case("R2 8-bit A5", 8'h00, 8'hA5, 8, 9'h0A5);
        tx_case("R2 8-bit 3E", 8'h00, 8'h3E, 8, 9'h03E);
        tx_case("R3 9th=1", C_WIDE | C_TX9, 8'h3C, 9, 9'h13C);
        tx_case("R3 9th=0", C_WIDE, 8'h81, 9, 9'h081);
        tx_case("R4 R5 8-bit even", C_PEN, 8'h07, 8, 9'h087);
        tx_case("R4 R5 8-bit odd", C_PEN | C_PODD, 8'h07, 8, 9'h007);
        tx_case("R4 R5 8-bit odd 55", C_PEN | C_PODD, 8'h55, 8, 9'h0D5);
        tx_case("R4 R5 9-bit even", C_WIDE | C_PEN, 8'h03, 9, 9'h003);
        tx_case("R4 R5 9-bit odd", C_WIDE | C_PEN | C_PODD, 8'h03, 9, 9'h103);
        reg_write(A_CTRL, 8'h00);
    endtask

    task automatic t_rx_basic();
        logic [7:0] v;
        reg_write(A_CTRL, 8'h00);
        send_rx(8, 9'h05A);
        reg_read(A_STAT, v);
        chk("R6 full set", int'(v[2]), 1);
        reg_read(A_DATA, v);
        chk("R6 data", int'(v), 8'h5A);
        reg_read(A_STAT, v);
        chk("R6 full cleared", int'(v[2]), 0);
        reg_write(A_CTRL, C_WIDE);
        send_rx(9, 9'h1C3);
        reg_read(A_DATA, v);
        chk("R3 rx low byte", int'(v), 8'hC3);
        reg_read(A_CTRL, v);
        chk("R3 rx ninth=1", int'(v[7]), 1);
        send_rx(9, 9'h0C3);
        reg_read(A_CTRL, v);
        chk("R3 rx ninth=0", int'(v[7]), 0);
        reg_write(A_CTRL, 8'h00);
        reg_read(A_DATA, v);
    endtask

    task automatic t_parity_err();
        logic [7:0] v;
        reg_write(A_CTRL, C_PEN | C_PIE);
        reg_read(A_DATA, v);
        send_rx(8, 9'h081);
        chk("R7 good parity no irq", int'(par_irq), 0);
        send_rx(8, 9'h001);
        chk("R7 bad parity irq", int'(par_irq), 1);
        reg_read(A_DATA, v);
        chk("R8 data alone keeps flag", int'(par_irq), 1);
        reg_read(A_STAT, v);
        chk("R7 status flag", int'(v[0]), 1);
        chk("R8 status read alone keeps flag", int'(par_irq), 1);
        reg_read(A_DATA, v);
        chk("R8 sequence clears irq", int'(par_irq), 0);
        reg_read(A_STAT, v);
        chk("R8 sequence clears flag", int'(v[0]), 0);
        reg_write(A_CTRL, C_PEN);
        send_rx(8, 9'h001);
        chk("R7 masked irq", int'(par_irq), 0);
        reg_read(A_STAT, v);
        chk("R7 masked flag set", int'(v[0]), 1);
        reg_read(A_DATA, v);
        reg_write(A_CTRL, 8'h00);
    endtask

    task automatic t_cfg_midframe();
        logic [8:0] w;
        logic       ok;
        logic [7:0] v;
        reg_write(A_CTRL, 8'h00);
        reg_write(A_DATA, 8'h07);
        fork
            capture_tx(8, w, ok);
            begin
                repeat (3 * BIT) @(negedge clk);
                reg_write(A_CTRL, C_PEN | C_PIE);
            end
        join
        chk("R9 tx old setting", int'(w), 9'h007);
        reg_write(A_DATA, 8'h07);
        capture_tx(8, w, ok);
        chk("R9 tx new setting", int'(w), 9'h087);
        reg_write(A_CTRL, C_PIE);
        reg_read(A_DATA, v);
        fork
            send_rx(8, 9'h001);
            begin
                repeat (3 * BIT) @(negedge clk);
                reg_write(A_CTRL, C_PEN | C_PIE);
            end
        join
        chk("R9 rx old setting", int'(par_irq), 0);
        send_rx(8, 9'h001);
        chk("R9 rx new setting", int'(par_irq), 1);
        reg_read(A_STAT, v);
        reg_read(A_DATA, v);
        reg_write(A_CTRL, 8'h00);
    endtask

    task automatic t_wide_lock();
        logic [7:0] v;
        reg_write(A_CTRL, 8'h00);
        reg_write(A_DATA, 8'h55);
        reg_write(A_CTRL, C_WIDE);
        reg_read(A_CTRL, v);
        chk("R10 write while busy dropped", int'(v[0]), 0);
        repeat (12 * BIT) @(negedge clk);
        reg_write(A_CTRL, C_WIDE);
        reg_read(A_CTRL, v);
        chk("R10 write while idle taken", int'(v[0]), 1);
        reg_write(A_CTRL, 8'h00);
    endtask

    task automatic t_disable();
        logic [8:0] w;
        logic       ok;
        logic [7:0] v;
        int         lows;
        reg_write(A_CTRL, 8'h00);
        reg_read(A_DATA, v);
        reg_write(A_DATA, 8'h0F);
        fork
            capture_tx(8, w, ok);
            reg_write(A_CTRL, C_OFF);
        join
        chk("R11 current frame completes", int'(w), 9'h00F);
        chk("R11 current frame stop", int'(ok), 1);
        reg_write(A_DATA, 8'h33);
        lows = 0;
        for (int i = 0; i < 12 * BIT; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R11 txd held high", lows, 0);
        reg_read(A_STAT, v);
        chk("R11 no tx busy", int'(v[1]), 0);
        send_rx(8, 9'h044);
        reg_read(A_STAT, v);
        chk("R11 rx not accepted", int'(v[2]), 0);
        reg_write(A_CTRL, 8'h00);
    endtask

    task automatic t_mute_addr();
        logic [7:0] v;
        reg_write(A_CTRL, C_WAKE);
        reg_read(A_DATA, v);
        reg_write(A_STAT, 8'h08);
        reg_read(A_STAT, v);
        chk("R12 muted", int'(v), 8'h08);
        send_rx(8, 9'h012);
        reg_read(A_STAT, v);
        chk("R12 plain word dropped", int'(v), 8'h08);
        send_rx(8, 9'h092);
        reg_read(A_STAT, v);
        chk("R12 mark wakes and delivers", int'(v), 8'h04);
        reg_read(A_DATA, v);
        chk("R12 mark word", int'(v), 8'h92);
    endtask

    task automatic t_mute_idle();
        logic [7:0] v;
        reg_write(A_CTRL, 8'h00);
        reg_read(A_DATA, v);
        reg_write(A_STAT, 8'h08);
        send_rx(8, 9'h092);
        reg_read(A_STAT, v);
        chk("R13 still muted after frame", int'(v), 8'h08);
        repeat (11 * BIT + 16) @(negedge clk);
        reg_read(A_STAT, v);
        chk("R13 idle frame wakes", int'(v), 8'h00);
        send_rx(8, 9'h021);
        reg_read(A_DATA, v);
        chk("R13 receives after wake", int'(v), 8'h21);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        reg_write(A_CTRL, 8'h00);
        reg_read(A_DATA, v);
        @(negedge clk);
        rxd = 1'b0;
        repeat (5 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        reg_read(A_STAT, v);
        chk("R14 glitch rejected", int'(v[2]), 0);
        send_rx(8, 9'h06D);
        reg_read(A_DATA, v);
        chk("R14 frame after glitch", int'(v), 8'h6D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_frames();
        t_rx_basic();
        t_parity_err();
        t_cfg_midframe();
        t_wide_lock();
        t_disable();
        t_mute_addr();
        t_mute_idle();
        t_glitch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule